// File: doc/BRIEF.md
# Comparison-Free Unary Minimum-Extraction Sorter

This block sorts a set of `NUM` unsigned `WIDTH`-bit values into ascending order without any magnitude comparator between the values. A single load pulse captures all inputs at once. The block then runs one round per output. In each round every input that has not yet been emitted drives a two-state machine. That machine produces a right-aligned unary stream of its value, timed by a shared window counter.

The counter `t` runs from 0 up to `2^WIDTH`. A machine holding value `v > 0` leaves its zero state when `t == 2^WIDTH - v`, so larger values switch earlier. A machine holding zero never switches. The current minimum belongs to the machines that switch last, and its value is `2^WIDTH - t` at that moment. If some machines are still in the zero state when the window ends, the minimum is zero.

Each extracted (value, index) pair is offered on a valid/ready output. The sort takes `NUM` rounds and is followed by a one-cycle done pulse. A new load at any point abandons the sort in progress and starts over with the new values.

Top module: `ums_sorter`

## Requirements
- R1: After a load, the block emits exactly `NUM` pairs, each index once, with values in non-decreasing order. Input `i` occupies bits `[i*WIDTH +: WIDTH]` of `loadData`, and `outValue` equals the loaded value of the input named by `outIndex`.
- R2: Inputs that share a value are emitted one after another, in increasing index order.
- R3: A value of 0 is found when the window ends at `t = 2^WIDTH`. The largest value `2^WIDTH-1` is found at `t = 1`.
- R4: Let the load be sampled at clock edge L. The first pair is valid just after edge `L + T + 1`, where `T = 2^WIDTH - vmin`, or `T = 2^WIDTH` when `vmin` is 0. After an accept at edge A, the next pair is valid after edge `A + T + 1` for that round's minimum.
- R5: While `outValid` is high and `outReady` is low, with no load, `outValid`, `outValue` and `outIndex` stay unchanged and no new round begins.
- R6: `donePulse` is high for exactly the one cycle after the edge that accepts the last pair, and at no other time.
- R7: A load while a sort is running or a pair is waiting drops `outValid` after that edge. It clears all emitted-state and restarts the sort on the new values. A load takes priority over an accept in the same cycle.
- R8: Out of reset, `outValid` and `donePulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| loadValid | input | 1 | One-cycle pulse that captures `loadData` and starts a sort |
| loadData | input | NUM*WIDTH | Packed input values, input `i` at `[i*WIDTH +: WIDTH]` |
| outReady | input | 1 | Consumer accepts the offered pair |
| outValid | output | 1 | A sorted pair is offered |
| outValue | output | WIDTH | Value of the offered pair |
| outIndex | output | $clog2(NUM) | Input index of the offered pair |
| donePulse | output | 1 | One-cycle flag after the last pair is accepted |

## Verification
The bench targets sets of equal values, several zeros, the largest value, and values in strictly descending index order. A design with a reversed tie priority, or one that fails to mask emitted inputs, would repeat an index or emit equal values in the wrong index order. A design that forgot the end-of-window case would never offer the zero entries. The bench measures the cycle of the first valid pair against the window arithmetic, so an off-by-one in the switch point or the counter is caught as a wrong value or a shifted valid. It also holds `outReady` low to catch pairs that drift. It reloads both mid-window and while a pair is waiting, to catch a stale pair or a leftover emitted flag.

// File: rtl/ums_pkg.sv
package ums_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ums_state_e;

  typedef struct packed {
    logic load;        // capture inputs, clear emitted flags, restart window
    logic roundStart;  // restart window, all lanes back to the zero state
    logic step;        // advance window by one tick
    logic capture;     // latch the found minimum, mark its lane emitted
  } ums_ctrl_t;

endpackage

// File: rtl/ums_datapath.sv
module ums_datapath
  import ums_pkg::*;
#(
  parameter int NUM   = 4,
  parameter int WIDTH = 4,
  localparam int IDXW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ums_ctrl_t              ctrl,
  input  logic [NUM*WIDTH-1:0]   loadData,
  output logic                   found,
  output logic [WIDTH-1:0]       outValue,
  output logic [IDXW-1:0]        outIndex
);

  localparam int CW = WIDTH + 1;
  localparam logic [CW-1:0] WINDOW_END = CW'(1) << WIDTH;

  logic [CW-1:0]    tick;
  logic [NUM-1:0]   zeroSt;
  logic [NUM-1:0]   emitted;
  logic [NUM-1:0]   switchNow;
  logic [NUM-1:0]   stillZero;
  logic [NUM-1:0]   winners;
  logic [WIDTH-1:0] laneVal [NUM];
  logic [IDXW-1:0]  pickIdx;
  logic [WIDTH-1:0] foundVal;

  // Shared window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tick <= '0;
    else if (ctrl.load || ctrl.roundStart) tick <= '0;
    else if (ctrl.step)                 tick <= tick + CW'(1);
  end

  // One two-state unary generator per input
  for (genvar i = 0; i < NUM; i++) begin : g_lane
    logic [CW-1:0] switchAt;
    assign switchAt     = WINDOW_END - {1'b0, laneVal[i]};
    assign switchNow[i] = !emitted[i] && zeroSt[i] &&
                          (laneVal[i] != '0) && (tick == switchAt);
    assign stillZero[i] = !emitted[i] && zeroSt[i] && !switchNow[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         laneVal[i] <= '0;
      else if (ctrl.load) laneVal[i] <= loadData[i*WIDTH +: WIDTH];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             zeroSt[i] <= 1'b1;
      else if (ctrl.load || ctrl.roundStart) zeroSt[i] <= 1'b1;
      else if (ctrl.step && switchNow[i])    zeroSt[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          emitted[i] <= 1'b0;
      else if (ctrl.load)                                 emitted[i] <= 1'b0;
      else if (ctrl.capture && pickIdx == IDXW'(i))       emitted[i] <= 1'b1;
    end
  end

  // Minimum detection: last switchers, or the lanes left at window end
  always_comb begin
    found    = 1'b0;
    winners  = '0;
    foundVal = '0;
    if (switchNow != '0 && stillZero == '0) begin
      found    = 1'b1;
      winners  = switchNow;
      foundVal = WIDTH'(WINDOW_END - tick);
    end else if (tick == WINDOW_END && stillZero != '0) begin
      found    = 1'b1;
      winners  = stillZero;
    end
  end

  // Lowest index among the winners goes first
  always_comb begin
    pickIdx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (winners[i]) pickIdx = IDXW'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValue <= '0;
      outIndex <= '0;
    end else if (ctrl.capture) begin
      outValue <= foundVal;
      outIndex <= pickIdx;
    end
  end

endmodule

// File: rtl/ums_control.sv
module ums_control
  import ums_pkg::*;
#(
  parameter int NUM = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadValid,
  input  logic      outReady,
  input  logic      found,
  output ums_ctrl_t ctrl,
  output logic      outValid,
  output logic      donePulse
);

  localparam int RCW = $clog2(NUM + 1);

  ums_state_e state, stateNxt;
  logic [RCW-1:0] roundCnt;
  logic lastRound;

  assign lastRound = (roundCnt == RCW'(NUM - 1));
  assign outValid  = (state == ST_HOLD);

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    if (loadValid) begin
      ctrl.load = 1'b1;
      stateNxt  = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN: begin
          ctrl.step = 1'b1;
          if (found) begin
            ctrl.capture = 1'b1;
            stateNxt     = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (outReady) begin
            if (lastRound) stateNxt = ST_IDLE;
            else begin
              ctrl.roundStart = 1'b1;
              stateNxt        = ST_RUN;
            end
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      roundCnt  <= '0;
      donePulse <= 1'b0;
    end else begin
      state     <= stateNxt;
      donePulse <= !loadValid && state == ST_HOLD && outReady && lastRound;
      if (loadValid)                                roundCnt <= '0;
      else if (state == ST_HOLD && outReady)        roundCnt <= roundCnt + RCW'(1);
    end
  end

endmodule

// File: rtl/ums_sorter.sv
module ums_sorter
  import ums_pkg::*;
#(
  parameter int NUM   = 4,
  parameter int WIDTH = 4,
  localparam int IDXW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadValid,
  input  logic [NUM*WIDTH-1:0] loadData,
  input  logic                 outReady,
  output logic                 outValid,
  output logic [WIDTH-1:0]     outValue,
  output logic [IDXW-1:0]      outIndex,
  output logic                 donePulse
);

  ums_ctrl_t ctrl;
  logic      found;

  ums_control #(.NUM(NUM)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .outReady(outReady),
    .found(found), .ctrl(ctrl), .outValid(outValid), .donePulse(donePulse)
  );

  ums_datapath #(.NUM(NUM), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .loadData(loadData),
    .found(found), .outValue(outValue), .outIndex(outIndex)
  );

endmodule

// File: rtl/ums_checker.sv
module ums_checker #(
  parameter int NUM   = 4,
  parameter int WIDTH = 4,
  localparam int IDXW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadValid,
  input logic             outReady,
  input logic             outValid,
  input logic [WIDTH-1:0] outValue,
  input logic [IDXW-1:0]  outIndex,
  input logic             donePulse
);

  logic             haveLast;
  logic [WIDTH-1:0] lastVal;
  logic [IDXW-1:0]  lastIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastVal  <= '0;
      lastIdx  <= '0;
    end else if (loadValid) begin
      haveLast <= 1'b0;
    end else if (outValid && outReady) begin
      haveLast <= 1'b1;
      lastVal  <= outValue;
      lastIdx  <= outIndex;
    end
  end

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    outValid && haveLast |-> outValue >= lastVal);  // R1

  AST_TIE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    outValid && haveLast && outValue == lastVal |-> outIndex > lastIdx);  // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !loadValid |=> outValid && $stable(outValue) && $stable(outIndex));  // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);  // R6

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(donePulse) |-> $past(outValid && outReady && !loadValid));  // R6

  AST_LOAD_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> !outValid && !donePulse);  // R7

endmodule

bind ums_sorter ums_checker #(.NUM(NUM), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .loadValid(loadValid), .outReady(outReady),
  .outValid(outValid), .outValue(outValue), .outIndex(outIndex),
  .donePulse(donePulse)
);

// File: tb/tb_ums_sorter.sv
`timescale 1ns/1ps
module tb_ums_sorter;

  localparam int NUM   = 4;
  localparam int WIDTH = 4;
  localparam int IDXW  = 2;
  localparam int NVEC  = 6;

  // Inputs packed with input i at [i*4 +: 4]; expected order with position k at [k*2 +: 2]
  localparam logic [15:0] VEC_IN  [NVEC] = '{16'h1935, 16'h7277, 16'h80F0,
                                             16'hCDEF, 16'h4444, 16'h0000};
  localparam logic [7:0]  VEC_ORD [NVEC] = '{8'b10_00_01_11, 8'b11_01_00_10,
                                             8'b01_11_10_00, 8'b00_01_10_11,
                                             8'b11_10_01_00, 8'b11_10_01_00};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0;
  logic [NUM*WIDTH-1:0] loadData = '0;
  logic outReady = 1'b0;
  logic outValid;
  logic [WIDTH-1:0] outValue;
  logic [IDXW-1:0]  outIndex;
  logic donePulse;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ums_sorter #(.NUM(NUM), .WIDTH(WIDTH)) dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadData(loadData),
    .outReady(outReady), .outValid(outValid), .outValue(outValue),
    .outIndex(outIndex), .donePulse(donePulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [15:0] data);
    @(negedge clk);
    loadValid = 1'b1;
    loadData  = data;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  // Collects all pairs after a load; the last load edge lies just before the call.
  task automatic drain(input logic [15:0] data, input logic [7:0] order, input bit stall);
    int vmin = 16;
    for (int i = 0; i < NUM; i++)
      if (int'(data[i*WIDTH +: WIDTH]) < vmin) vmin = int'(data[i*WIDTH +: WIDTH]);
    for (int k = 0; k < NUM; k++) begin
      int c = 0;
      int ei = int'(order[k*2 +: 2]);
      int ev = int'(data[ei*WIDTH +: WIDTH]);
      while (!outValid && c < 100) begin
        @(negedge clk);
        c++;
      end
      if (k == 0) check("R4 first-pair latency", c, (vmin == 0) ? 17 : 17 - vmin);
      check("R1/R2 index", int'(outIndex), ei);
      check("R1/R3 value", int'(outValue), ev);
      if (stall) begin
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          check("R5 held valid", int'(outValid), 1);
          check("R5 held index", int'(outIndex), ei);
          check("R5 held value", int'(outValue), ev);
        end
      end
      outReady = 1'b1;
      @(negedge clk);
      outReady = 1'b0;
      if (k == NUM - 1) begin
        check("R6 done after last accept", int'(donePulse), 1);
        @(negedge clk);
        check("R6 done one cycle", int'(donePulse), 0);
        check("R6 idle after sort", int'(outValid), 0);
      end else begin
        check("R6 no early done", int'(donePulse), 0);
        check("R4 valid drops for next round", int'(outValid), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset outValid", int'(outValid), 0);
    check("R8 reset donePulse", int'(donePulse), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      doLoad(VEC_IN[v]);
      drain(VEC_IN[v], VEC_ORD[v], (v % 2) == 1);
    end

    // R7: reload while a pair is waiting
    doLoad(VEC_IN[0]);
    while (!outValid) @(negedge clk);
    doLoad(VEC_IN[3]);
    check("R7 valid drops on reload", int'(outValid), 0);
    drain(VEC_IN[3], VEC_ORD[3], 1'b0);

    // R7: reload mid-window restarts from the new values and clears emitted flags
    doLoad(VEC_IN[2]);
    repeat (5) @(negedge clk);
    doLoad(VEC_IN[0]);
    drain(VEC_IN[0], VEC_ORD[0], 1'b0);

    // R7: reload after some pairs were already emitted
    doLoad(VEC_IN[1]);
    while (!outValid) @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    doLoad(VEC_IN[1]);
    drain(VEC_IN[1], VEC_ORD[1], 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule